// File: doc/BRIEF.md
# Register-Controlled Shifter with Carry-Out

This block shifts or rotates a 32-bit operand by an amount taken from another 32-bit operand. Only the low byte of that operand counts. Four shift kinds are offered: logical left, logical right, arithmetic right and rotate right. Each operation produces a shifted result and a carry-out.

The carry-out is held in a carry-flag register. That register is also the carry-in for the next operation: when the effective amount is zero, the old carry value is kept.

An operation is presented with `valid_in` high. On that clock edge the result register loads the shifted value. The carry register loads the new carry only when `update_flags` is also high. Amounts of exactly the data width, and amounts above it, follow fixed per-kind rules, as listed below.

Top module: `flag_shifter`

## Requirements
- R1: Only `shift_amt[7:0]` affects the operation. Bits 31:8 of `shift_amt` have no effect on the result or on the carry.
- R2: With `shift_amt[7:0]` equal to 0, every shift kind returns `data_in` unchanged and leaves `carry_flag` at its previous value.
- R3: `shift_op` = 0 selects logical left. For an amount n in 1..31 the result is `data_in << n` and the carry is `data_in[32-n]`. For n = 32 the result is 0 and the carry is `data_in[0]`. For n > 32 the result is 0 and the carry is 0.
- R4: `shift_op` = 1 selects logical right. For n in 1..31 the result is `data_in >> n` and the carry is `data_in[n-1]`. For n = 32 the result is 0 and the carry is `data_in[31]`. For n > 32 the result is 0 and the carry is 0.
- R5: `shift_op` = 2 selects arithmetic right. For n in 1..31 the result is the sign-filled shift and the carry is `data_in[n-1]`. For n of 32 or more, every result bit and the carry equal `data_in[31]`.
- R6: `shift_op` = 3 selects rotate right by r = n mod 32. When r is nonzero, the result is `data_in` rotated right by r and the carry is `data_in[r-1]`.
- R7: Rotate right with n a nonzero multiple of 32 returns `data_in` unchanged and sets the carry to `data_in[31]`.
- R8: `result` loads only on a clock edge where `valid_in` is high. Otherwise it holds its value.
- R9: `carry_flag` loads only on an edge where both `valid_in` and `update_flags` are high. Otherwise it holds its value.
- R10: A synchronous active-low reset clears both `result` and `carry_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operation strobe |
| shift_op | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| update_flags | input | 1 | Write the carry register for this operation |
| data_in | input | 32 | Operand to shift |
| shift_amt | input | 32 | Amount operand; only bits 7:0 are used |
| result | output | 32 | Registered shifted value |
| carry_flag | output | 1 | Carry-flag register, also the carry-in |

## Verification
The assertions assume that the inputs are stable and known at each rising edge once reset is released. They also assume that `shift_op` always holds one of its four defined codes, which a 2-bit field ensures.

The stimulus is applied on falling edges. It walks every shift kind through all 256 low-byte amounts, using several bit patterns. The upper amount bits are scrambled and `update_flags` is toggled along the way, so every region of each kind, including 0, 32 and above 32, is visited with known inputs.

// File: rtl/flag_shifter_pkg.sv
// Shared types for the register-controlled shifter.
// Assumes: the 2-bit shift selector encoding below is fixed for decoders.
package flag_shifter_pkg;
    typedef enum logic [1:0] {
        SHK_LSL = 2'd0,
        SHK_LSR = 2'd1,
        SHK_ASR = 2'd2,
        SHK_ROR = 2'd3
    } shift_kind_e;
endpackage

// File: rtl/shamt_classify.sv
// Classifies the effective shift amount into the regions that the shift
// rules distinguish: zero, equal to the width, above the width, and the
// amount modulo the width.
// Assumes: DATA_W is a power of two and fits in AMT_W bits.
module shamt_classify #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0] amt,
    output logic             is_zero,
    output logic             is_width,
    output logic             is_over,
    output logic             mod_zero,
    output logic [SH_W-1:0]  amt_mod
);
    localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(DATA_W);

    // Region decode of the low-byte amount
    always_comb begin
        is_zero  = (amt == '0);
        is_width = (amt == WIDTH_AMT);
        is_over  = (amt > WIDTH_AMT);
        amt_mod  = amt[SH_W-1:0];
        mod_zero = (amt[SH_W-1:0] == '0);
    end
endmodule

// File: rtl/shift_datapath.sv
// Combinational shift/rotate with carry-out for one operation.
// Assumes: region flags come from shamt_classify for the same amount;
// carry_in is the current carry register, returned when the amount is 0.
module shift_datapath
    import flag_shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  shift_kind_e        kind,
    input  logic [DATA_W-1:0]  din,
    input  logic               carry_in,
    input  logic               is_zero,
    input  logic               is_width,
    input  logic               is_over,
    input  logic               mod_zero,
    input  logic [SH_W-1:0]    amt_mod,
    output logic [DATA_W-1:0]  dout,
    output logic               carry_out
);
    logic [DATA_W:0]   left_ext;
    logic [DATA_W:0]   right_ext;
    logic [DATA_W:0]   arith_ext;
    logic [2*DATA_W-1:0] rot_ext;
    logic              msb;

    // Extended shifts: the extra bit collects the last bit shifted out
    always_comb begin
        msb       = din[DATA_W-1];
        left_ext  = {1'b0, din} << amt_mod;
        right_ext = {din, 1'b0} >> amt_mod;
        arith_ext = $unsigned($signed({din, 1'b0}) >>> amt_mod);
        rot_ext   = {din, din} >> amt_mod;
    end

    // Per-kind selection of result and carry by amount region
    always_comb begin
        dout      = din;
        carry_out = carry_in;
        if (!is_zero) begin
            unique case (kind)
                SHK_LSL: begin
                    if (is_over) begin
                        dout = '0; carry_out = 1'b0;
                    end else if (is_width) begin
                        dout = '0; carry_out = din[0];
                    end else begin
                        dout = left_ext[DATA_W-1:0]; carry_out = left_ext[DATA_W];
                    end
                end
                SHK_LSR: begin
                    if (is_over) begin
                        dout = '0; carry_out = 1'b0;
                    end else if (is_width) begin
                        dout = '0; carry_out = msb;
                    end else begin
                        dout = right_ext[DATA_W:1]; carry_out = right_ext[0];
                    end
                end
                SHK_ASR: begin
                    if (is_over || is_width) begin
                        dout = {DATA_W{msb}}; carry_out = msb;
                    end else begin
                        dout = arith_ext[DATA_W:1]; carry_out = arith_ext[0];
                    end
                end
                SHK_ROR: begin
                    if (mod_zero) begin
                        dout = din; carry_out = msb;
                    end else begin
                        dout = rot_ext[DATA_W-1:0]; carry_out = rot_ext[DATA_W-1];
                    end
                end
                default: begin
                    dout = din; carry_out = carry_in;
                end
            endcase
        end
    end
endmodule

// File: rtl/flag_shifter.sv
// Top of the register-controlled shifter: classifies the low-byte amount,
// runs the datapath and registers the result and the carry flag.
// Assumes: inputs are stable around the rising edge; reset is synchronous
// and active low.
module flag_shifter
    import flag_shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [1:0]        shift_op,
    input  logic              update_flags,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] shift_amt,
    output logic [DATA_W-1:0] result,
    output logic              carry_flag
);
    logic              amt_zero, amt_width, amt_over, amt_mod_zero;
    logic [SH_W-1:0]   amt_mod;
    logic [DATA_W-1:0] next_result;
    logic              next_carry;
    logic              unused_amt_hi;
    shift_kind_e       kind;
    logic [AMT_W-1:0]  amt_low;

    // Only the low amount bits are decoded; the rest are dropped here
    assign amt_low       = shift_amt[AMT_W-1:0];
    assign unused_amt_hi = ^shift_amt[DATA_W-1:AMT_W];
    assign kind          = shift_kind_e'(shift_op);

    shamt_classify #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_classify (
        .amt      (amt_low),
        .is_zero  (amt_zero),
        .is_width (amt_width),
        .is_over  (amt_over),
        .mod_zero (amt_mod_zero),
        .amt_mod  (amt_mod)
    );

    shift_datapath #(.DATA_W(DATA_W)) u_path (
        .kind      (kind),
        .din       (data_in),
        .carry_in  (carry_flag),
        .is_zero   (amt_zero),
        .is_width  (amt_width),
        .is_over   (amt_over),
        .mod_zero  (amt_mod_zero),
        .amt_mod   (amt_mod),
        .dout      (next_result),
        .carry_out (next_carry)
    );

    // Result register: loads on a valid operation
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (valid_in)
            result <= next_result;
    end

    // Carry register: loads on a valid operation that requests a flag write
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_flag <= 1'b0;
        else if (valid_in && update_flags)
            carry_flag <= next_carry;
    end

    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && carry_flag == 1'b0));

    a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(result));

    a_r9_carry_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_in && update_flags) |=> $stable(carry_flag));

    a_r2_zero_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && shift_amt[AMT_W-1:0] == '0)
        |=> (result == $past(data_in) && carry_flag == $past(carry_flag)));

    a_r5_asr_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && shift_op == 2'd2 && shift_amt[AMT_W-1:0] >= AMT_W'(DATA_W))
        |=> (result == {DATA_W{$past(data_in[DATA_W-1])}}));

    a_r3_lsl_over_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && update_flags && shift_op == 2'd0 && shift_amt[AMT_W-1:0] > AMT_W'(DATA_W))
        |=> (result == '0 && !carry_flag));

    a_r7_ror_whole_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && update_flags && shift_op == 2'd3 && shift_amt[AMT_W-1:0] != '0
         && shift_amt[SH_W-1:0] == '0)
        |=> (result == $past(data_in) && carry_flag == $past(data_in[DATA_W-1])));
endmodule

// File: tb/flag_shifter_test.sv
// Sweeps every shift kind over all low-byte amounts with several patterns;
// expected values come from wide arithmetic shifts in the bench.
module flag_shifter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [1:0]  shift_op = 2'd0;
    logic        update_flags = 1'b0;
    logic [31:0] data_in = '0;
    logic [31:0] shift_amt = '0;
    logic [31:0] result;
    logic        carry_flag;

    int total = 0;
    int fails = 0;
    logic exp_c = 1'b0;
    logic [31:0] exp_r = '0;

    always #4ns clk = ~clk;

    flag_shifter uut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .shift_op(shift_op),
        .update_flags(update_flags), .data_in(data_in), .shift_amt(shift_amt),
        .result(result), .carry_flag(carry_flag)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s result act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s carry act=%b exp=%b", tag, act, exp);
        end
    endtask

    function automatic string req_tag(input int op, input int n);
        if (n == 0) return "R2";
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return (n % 32 == 0) ? "R7" : "R6";
        endcase
    endfunction

    // Reference model: result and carry from wide shifts
    task automatic model(input int op, input int n, input logic [31:0] d,
                         input logic cin, output logic [31:0] r, output logic c);
        logic [63:0] w;
        r = d; c = cin;
        if (n == 0) return;
        case (op)
            0: if (n > 32) begin r = 0; c = 0; end
               else begin w = {32'b0, d} << n; r = w[31:0]; c = w[32]; end
            1: if (n > 32) begin r = 0; c = 0; end
               else begin w = {d, 32'b0} >> n; r = w[63:32]; c = w[31]; end
            2: begin
                w = $unsigned($signed({d, 32'b0}) >>> ((n > 32) ? 32 : n));
                r = w[63:32]; c = w[31];
            end
            default: begin
                w = {d, d} >> (n % 32);
                r = w[31:0]; c = r[31];
            end
        endcase
    endtask

    initial begin
        #1600000ns;
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        logic [31:0] er;
        logic ec;
        pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hA5C3_0F96; pats[3] = 32'h1234_5678;

        repeat (3) @(negedge clk);
        check32("R10", result, 32'h0);
        check1("R10", carry_flag, 1'b0);
        rst_n = 1'b1;

        for (int op = 0; op < 4; op++) begin
            for (int p = 0; p < 4; p++) begin
                for (int n = 0; n < 256; n++) begin
                    logic uf;
                    string tag;
                    uf = (n % 3) != 1;
                    @(negedge clk);
                    valid_in = 1'b1;
                    shift_op = 2'(op);
                    update_flags = uf;
                    data_in = pats[p] ^ (32'(n) * 32'h0101_0101);
                    // R1: upper amount bits scrambled on every vector
                    shift_amt = {$urandom() % 32'h0100_0000, 8'(n)} ;
                    shift_amt[31:8] = 24'($urandom());
                    model(op, n, data_in, exp_c, er, ec);
                    exp_r = er;
                    if (uf) exp_c = ec;
                    tag = {req_tag(op, n), "/R1"};
                    @(negedge clk);
                    valid_in = 1'b0;
                    check32(tag, result, exp_r);
                    check1(uf ? tag : "R9", carry_flag, exp_c);
                end
            end
        end

        // R8: no load while valid_in is low
        @(negedge clk);
        valid_in = 1'b0; data_in = ~exp_r; shift_op = 2'd3; shift_amt = 32'd5; update_flags = 1'b1;
        @(negedge clk);
        check32("R8", result, exp_r);
        check1("R9", carry_flag, exp_c);

        // R1: same low byte, different upper bits, same outcome
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            valid_in = 1'b1; shift_op = 2'd1; update_flags = 1'b1;
            data_in = 32'hF000_0008; shift_amt = (k == 0) ? 32'h0000_0004 : 32'hFFFF_FF04;
            @(negedge clk);
            valid_in = 1'b0;
            check32("R1", result, 32'h0F00_0000);
            check1("R1", carry_flag, 1'b1);
        end

        // R10: reset after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check32("R10", result, 32'h0);
        check1("R10", carry_flag, 1'b0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule